// File: doc/BRIEF.md
# Packed-decimal ripple adder

This block adds two unsigned packed BCD numbers of a parameterised number of digits (three by default) and returns a packed BCD sum one digit wider, whose top digit holds the final decimal carry. It is purely combinational. Digit i of an operand sits in bits 4i+3 down to 4i, with digit 0 the least significant.

Each digit position first forms the plain binary sum of its two nibbles and the carry handed up by the digit below. When that binary sum exceeds nine, six is added to it. The low four bits become the result digit and a decimal carry of one passes upward. Because the carry into a digit is the carry produced after the lower digit has been corrected, a digit whose own nibbles add to nine becomes ten once a carry arrives, and it is corrected in turn. The correction therefore walks up the digit chain one position at a time.

A validity flag for every input nibble reports whether it holds a legal decimal code. Illegal nibbles do not stop the addition. The same per-digit rule is still applied to them, and the flags tell the user that the result means nothing.

Top module: `bcd_ripple_adder`

## Requirements
- R1: For each digit i (bits 4i+3:4i, digit 0 least significant), the block forms the binary total T = a_i + b_i + c_i. Here c_0 = 0, and c_i is the decimal carry out of digit i-1.
- R2: When T > 9, sum digit i equals the low four bits of T + 6, and the decimal carry out of digit i is 1. For example, 8 + 5 gives digit 3 with a carry.
- R3: When T <= 9, sum digit i equals T and the carry out is 0. For example, 7 + 2 gives 9 and leaves the digit unchanged.
- R4: The carry into a digit is the corrected carry of the digit below. A digit whose nibbles sum to 9 therefore rolls over when that carry is 1: 099 + 001 gives 0100, and 095 + 005 gives 0100.
- R5: Sum bits 4N+3:4N (N = digit count) hold the decimal carry out of the top digit. They are always 0000 or 0001: 999 + 999 gives 1998, and 500 + 500 gives 1000.
- R6: ok_a[i] is 1 exactly when a's digit i is 0 to 9, and 0 for codes 1010 to 1111. ok_b[i] works the same way for b. For example, a = A3F (hex) gives ok_a = 010.
- R7: Illegal nibbles do not block the addition. The R1 to R3 rule is still applied, so 00F + 001 gives 0016.
- R8: When every nibble of both operands is legal, the sum read as a decimal number equals the decimal sum of the operands, and every sum digit is 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4*DIGITS | First operand, packed BCD |
| b | input | 4*DIGITS | Second operand, packed BCD |
| sum | output | 4*DIGITS+4 | Packed BCD sum; the top digit is the decimal carry |
| ok_a | output | DIGITS | Per-digit legal-code flags for a |
| ok_b | output | DIGITS | Per-digit legal-code flags for b |

## Verification
The bench goes after chains of nines fed by a carry from below, such as 099 + 001 and 999 + 999. A design that corrected every digit in parallel from the uncorrected sums would leave a digit reading 1010 there, or would drop the carry into the hundreds. It also probes the boundary totals of nine and ten in every digit. An off-by-one threshold would either skip the +6 on ten or wrongly correct nine. Illegal nibbles with sums of up to 31 are exercised as well: a design that saturated or masked them would disagree with the per-digit rule, and a flag tied to the wrong nibble shows up in the A3F-style patterns.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;

    localparam int NIB_W   = 4;
    localparam int RAW_W   = NIB_W + 1;
    localparam int MAX_DEC = 9;
    localparam int FIX_ADD = 16 - (MAX_DEC + 1);

    typedef logic [NIB_W-1:0] digit_t;
    typedef logic [RAW_W-1:0] raw_t;

    typedef struct packed {
        digit_t digit;
        logic   cout;
    } digit_res_t;

    function automatic logic is_legal(input digit_t d);
        return (d <= digit_t'(MAX_DEC));
    endfunction

    function automatic logic over_nine(input raw_t r);
        return (r > raw_t'(MAX_DEC));
    endfunction

endpackage

// File: rtl/bcd_nibble_valid.sv
module bcd_nibble_valid
    import bcd_add_pkg::*;
(
    input  digit_t nib,
    output logic   legal
);
    always_comb legal = is_legal(nib);
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
    import bcd_add_pkg::*;
(
    input  digit_t     x,
    input  digit_t     y,
    input  logic       cin,
    output digit_res_t res
);
    raw_t raw;
    raw_t fixed;
    logic corr;

    always_comb begin
        raw   = raw_t'(x) + raw_t'(y) + raw_t'(cin);
        corr  = over_nine(raw);
        fixed = corr ? (raw + raw_t'(FIX_ADD)) : raw;
        res.digit = fixed[NIB_W-1:0];
        res.cout  = corr;
    end
endmodule

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder
    import bcd_add_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic [NIB_W*DIGITS-1:0]       a,
    input  logic [NIB_W*DIGITS-1:0]       b,
    output logic [NIB_W*DIGITS+NIB_W-1:0] sum,
    output logic [DIGITS-1:0]             ok_a,
    output logic [DIGITS-1:0]             ok_b
);
    localparam int OP_W = NIB_W * DIGITS;

    logic [DIGITS:0] dcarry;
    assign dcarry[0] = 1'b0;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        digit_res_t r;

        bcd_nibble_valid u_va (.nib(a[NIB_W*g +: NIB_W]), .legal(ok_a[g]));
        bcd_nibble_valid u_vb (.nib(b[NIB_W*g +: NIB_W]), .legal(ok_b[g]));

        bcd_digit_adder u_add (
            .x   (a[NIB_W*g +: NIB_W]),
            .y   (b[NIB_W*g +: NIB_W]),
            .cin (dcarry[g]),
            .res (r)
        );

        assign sum[NIB_W*g +: NIB_W] = r.digit;
        assign dcarry[g+1]           = r.cout;
    end

    assign sum[OP_W +: NIB_W] = {{(NIB_W-1){1'b0}}, dcarry[DIGITS]};
endmodule

// File: rtl/bcd_ripple_adder_chk.sv
module bcd_ripple_adder_chk #(
    parameter int DIGITS = 3
) (
    input logic [4*DIGITS-1:0] a,
    input logic [4*DIGITS-1:0] b,
    input logic [4*DIGITS+3:0] sum,
    input logic [DIGITS-1:0]   ok_a,
    input logic [DIGITS-1:0]   ok_b,
    input logic [DIGITS:0]     carry
);
    int  t;
    int  d;
    logic all_ok;

    always_comb begin
        all_ok = (&ok_a) && (&ok_b);
        // R5
        top_digit_chk: assert (sum[4*DIGITS+3:4*DIGITS+1] == 3'b000);
        for (int i = 0; i < DIGITS; i++) begin
            t = int'(a[4*i +: 4]) + int'(b[4*i +: 4]) + int'(carry[i]);
            d = int'(sum[4*i +: 4]);
            if (ok_a[i] && ok_b[i]) begin
                // R4
                carry_rule_chk: assert (carry[i+1] == (t > 9));
                // R3
                pass_through_chk: assert ((t > 9) || (d == t));
                // R2
                corrected_digit_chk: assert ((t <= 9) || (d == t - 10));
            end
            // R8
            if (all_ok) begin
                legal_out_chk: assert (d <= 9);
            end
        end
    end
endmodule

bind bcd_ripple_adder bcd_ripple_adder_chk #(.DIGITS(DIGITS)) u_chk (
    .a(a), .b(b), .sum(sum), .ok_a(ok_a), .ok_b(ok_b), .carry(dcarry)
);

// File: tb/tb_bcd_ripple_adder.sv
module tb_bcd_ripple_adder;
    localparam int N = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [4*N-1:0] a, b;
    logic [4*N+3:0] sum;
    logic [N-1:0]   ok_a, ok_b;

    int checks = 0;
    int errors = 0;

    bcd_ripple_adder #(.DIGITS(N)) dut (
        .a(a), .b(b), .sum(sum), .ok_a(ok_a), .ok_b(ok_b)
    );

    function automatic logic [4*N-1:0] to_bcd(input int n);
        logic [4*N-1:0] v = '0;
        int m = n;
        for (int i = 0; i < N; i++) begin
            v[4*i +: 4] = 4'(m % 10);
            m = m / 10;
        end
        return v;
    endfunction

    function automatic int from_bcd(input logic [4*N+3:0] v);
        int r = 0;
        for (int i = N; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
        return r;
    endfunction

    // Digit rule from the requirements, evaluated with integers.
    function automatic logic [4*N+3:0] model_sum(input logic [4*N-1:0] x, y);
        logic [4*N+3:0] s = '0;
        int c = 0;
        for (int i = 0; i < N; i++) begin
            int t = int'(x[4*i +: 4]) + int'(y[4*i +: 4]) + c;
            if (t > 9) begin
                s[4*i +: 4] = 4'((t + 6) % 16);
                c = 1;
            end else begin
                s[4*i +: 4] = 4'(t);
                c = 0;
            end
        end
        s[4*N +: 4] = 4'(c);
        return s;
    endfunction

    function automatic logic [N-1:0] model_ok(input logic [4*N-1:0] x);
        logic [N-1:0] f;
        for (int i = 0; i < N; i++) f[i] = (x[4*i +: 4] <= 4'd9);
        return f;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [4*N-1:0] x, y);
        @(posedge clk);
        #1;
        a = x;
        b = y;
        @(negedge clk);
    endtask

    task automatic run_vec(input string tag, input logic [4*N-1:0] x, y);
        drive(x, y);
        check(tag, int'(sum), int'(model_sum(x, y)));
        check({tag, "/R6 flags a"}, int'(ok_a), int'(model_ok(x)));
        check({tag, "/R6 flags b"}, int'(ok_b), int'(model_ok(y)));
    endtask

    task automatic run_dec(input string tag, input int x, y);
        run_vec(tag, to_bcd(x), to_bcd(y));
        check({tag, "/R8 decimal"}, from_bcd(sum), x + y);
    endtask

    initial begin
        #(150000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int blist [12] = '{0, 1, 9, 10, 99, 100, 111, 450, 500, 901, 998, 999};
        a = '0;
        b = '0;
        drive('0, '0);
        check("R1 zero inputs", int'(sum), 0);
        check("R6 zero flags", int'({ok_a, ok_b}), 6'h3f);

        drive(12'h007, 12'h002); check("R3 pass 7+2", int'(sum), 16'h0009);
        drive(12'h008, 12'h005); check("R2 fix 8+5", int'(sum), 16'h0013);
        drive(12'h009, 12'h000); check("R3 nine kept", int'(sum), 16'h0009);
        drive(12'h009, 12'h001); check("R2 ten fixed", int'(sum), 16'h0010);
        drive(12'h099, 12'h001); check("R4 roll 099+001", int'(sum), 16'h0100);
        drive(12'h095, 12'h005); check("R4 roll 095+005", int'(sum), 16'h0100);
        drive(12'h999, 12'h999); check("R5 999+999", int'(sum), 16'h1998);
        drive(12'h500, 12'h500); check("R5 500+500", int'(sum), 16'h1000);
        drive(12'h999, 12'h001); check("R5 999+001", int'(sum), 16'h1000);
        drive(12'hA3F, 12'h123);
        check("R6 flags A3F", int'(ok_a), 3'b010);
        check("R6 flags 123", int'(ok_b), 3'b111);
        drive(12'h00F, 12'h001); check("R7 00F+001", int'(sum), 16'h0016);
        drive(12'hFFF, 12'hFFF); check("R7 FFF+FFF", int'(sum), int'(model_sum(12'hFFF, 12'hFFF)));

        for (int x = 0; x < 1000; x++)
            for (int k = 0; k < 12; k++)
                run_dec("R8 sweep", x, blist[k]);

        for (int k = 0; k < 15000; k++)
            run_dec("R8 random", int'($urandom % 1000), int'($urandom % 1000));

        for (int k = 0; k < 4000; k++)
            run_vec("R7 random nibbles", 12'($urandom), 12'($urandom));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule